// File: doc/BRIEF.md
# Shadow-Loaded RGB Panel Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-clock-enable strobes that drive an RGB panel. A simple write port programs the pulse width, back porch, front porch and active size of each axis. It also programs a pixel clock divider, a video enable, a per-frame enable and a frame interrupt. All timing fields are stored as count minus one.

Timing and per-frame fields are written into a pending register set. They are copied into the working set only at a frame boundary, which is the instant vertical sync begins. An update-protect bit holds back that copy, so software can change several fields without the counters ever running on a half-updated set. A frame interrupt raises a sticky status bit at each frame start. Writing one to that bit clears it.

Each line runs sync, back porch, active, front porch, in pixels. Each frame runs the same four phases, counted in lines. Data enable is high only while both axes are in their active phase.

Top module: `panel_timing_gen`

## Requirements
- R1: After a synchronous reset, o_hsync, o_vsync, o_de, o_pclk_en and o_frame_irq are all low. Video and the per-frame enable are off.
- R2: A line lasts (hsw+1)+(hbp+1)+(hact+1)+(hfp+1) pixel periods. o_hsync is high for the first hsw+1 of them. Register 2 holds the horizontal fields: sync width at [7:0], back porch at [15:8], front porch at [23:16].
- R3: A frame lasts (vsw+1)+(vbp+1)+(vact+1)+(vfp+1) lines. o_vsync is high for the first vsw+1 lines. Register 1 holds the vertical fields at the same bit positions as register 2.
- R4: o_de is high only where both axes are active, giving (hact+1)*(vact+1) pixels per frame. The first active pixel comes (vsw+vbp+2) lines plus (hsw+hbp+2) pixels after o_vsync rises. Register 3 holds active width minus one at [15:0] and active height minus one at [31:16].
- R5: Register 0 holds the control fields: bit 2 is the divide-direction bit and [15:8] is the divisor minus one. With bit 2 clear, the pixel period is one source cycle whatever the divisor. With bit 2 set, the pixel period is divisor+1 source cycles. o_pclk_en pulses once per pixel period.
- R6: Writes to registers 0 to 3 do not change the running timing. They take effect at the next frame boundary.
- R7: While bit 0 of register 6 (protect) is set, frame boundaries do not load pending values. The values load at the first boundary after protect is cleared.
- R8: Output runs only while both video enable (register 0 bit 0) and the per-frame enable (register 0 bit 1) are set. The video enable acts at once. The per-frame enable acts from the next boundary. Otherwise all four strobes stay low.
- R9: o_frame_irq sets at a frame boundary when register 4 bit 0 (global enable), register 4 bit 1 (frame enable) and video enable are all set. It does not set when either interrupt enable is clear.
- R10: Writing 1 to register 5 bit 0 clears o_frame_irq. Writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| o_pclk_en | output | 1 | One-cycle pulse per pixel period |
| o_hsync | output | 1 | Horizontal sync, active high |
| o_vsync | output | 1 | Vertical sync, active high |
| o_de | output | 1 | Data enable |
| o_frame_irq | output | 1 | Sticky frame interrupt status |

## Verification
A wrong phase counter or limit shows up within one frame. The frame length, the sync widths, the count of data-enable cycles or the offset of the first active pixel from the vsync edge will disagree with the arithmetic from the programmed fields. A working set that loads early, or loads while protected, alters the length of the very frame in which the write happened. The protected case shows within two frames. A faulty divider changes frame length by a whole multiple of the line count, and it does so in the first frame after the change. Errors in the interrupt flag show in the cycle after a boundary or a status write.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } ptg_phase_e;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_VERT  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_HORZ  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_SIZE  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_IRQEN = 3'd4;
  localparam logic [ADDR_W-1:0] REG_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] REG_PROT  = 3'd6;

  localparam int CTRL_VIDEO   = 0;
  localparam int CTRL_FRAME   = 1;
  localparam int CTRL_DIR     = 2;
  localparam int CTRL_DIV_LSB = 8;
  localparam int AX_SW_LSB    = 0;
  localparam int AX_BP_LSB    = 8;
  localparam int AX_FP_LSB    = 16;
  localparam int SZ_W_LSB     = 0;
  localparam int SZ_H_LSB     = 16;
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
  import ptg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 11,
  parameter int DIV_W   = 8,
  parameter int DEF_ACT = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         frame_tick,
  output logic [1:0][PORCH_W-1:0]      sw_o,
  output logic [1:0][PORCH_W-1:0]      bp_o,
  output logic [1:0][PORCH_W-1:0]      fp_o,
  output logic [1:0][SIZE_W-1:0]       act_o,
  output logic [DIV_W-1:0]             div_o,
  output logic                         dir_o,
  output logic                         frame_en_o,
  output logic                         video_en_o,
  output logic                         protect_o,
  output logic                         gie_o,
  output logic                         fie_o,
  output logic                         stat_clr_o
);
  logic [1:0][PORCH_W-1:0] p_sw, p_bp, p_fp;
  logic [1:0][SIZE_W-1:0]  p_act;
  logic [DIV_W-1:0]        p_div;
  logic                    p_dir, p_frame;
  logic                    load;

  assign load       = frame_tick && !protect_o;
  assign stat_clr_o = wr_en && (wr_addr == REG_STAT) && wr_data[0];

  // pending set and immediate controls
  always_ff @(posedge clk) begin
    if (rst) begin
      p_sw       <= '0;
      p_bp       <= '0;
      p_fp       <= '0;
      p_act      <= {2{SIZE_W'(DEF_ACT)}};
      p_div      <= '0;
      p_dir      <= 1'b0;
      p_frame    <= 1'b0;
      video_en_o <= 1'b0;
      protect_o  <= 1'b0;
      gie_o      <= 1'b0;
      fie_o      <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_addr)
        REG_CTRL: begin
          video_en_o <= wr_data[CTRL_VIDEO];
          p_frame    <= wr_data[CTRL_FRAME];
          p_dir      <= wr_data[CTRL_DIR];
          p_div      <= wr_data[CTRL_DIV_LSB +: DIV_W];
        end
        REG_VERT: begin
          p_sw[1] <= wr_data[AX_SW_LSB +: PORCH_W];
          p_bp[1] <= wr_data[AX_BP_LSB +: PORCH_W];
          p_fp[1] <= wr_data[AX_FP_LSB +: PORCH_W];
        end
        REG_HORZ: begin
          p_sw[0] <= wr_data[AX_SW_LSB +: PORCH_W];
          p_bp[0] <= wr_data[AX_BP_LSB +: PORCH_W];
          p_fp[0] <= wr_data[AX_FP_LSB +: PORCH_W];
        end
        REG_SIZE: begin
          p_act[0] <= wr_data[SZ_W_LSB +: SIZE_W];
          p_act[1] <= wr_data[SZ_H_LSB +: SIZE_W];
        end
        REG_IRQEN: begin
          gie_o <= wr_data[0];
          fie_o <= wr_data[1];
        end
        REG_PROT:  protect_o <= wr_data[0];
        default: ;
      endcase
    end
  end

  // working set, loaded only at an unprotected frame boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_o       <= '0;
      bp_o       <= '0;
      fp_o       <= '0;
      act_o      <= {2{SIZE_W'(DEF_ACT)}};
      div_o      <= '0;
      dir_o      <= 1'b0;
      frame_en_o <= 1'b0;
    end else if (load) begin
      sw_o       <= p_sw;
      bp_o       <= p_bp;
      fp_o       <= p_fp;
      act_o      <= p_act;
      div_o      <= p_div;
      dir_o      <= p_dir;
      frame_en_o <= p_frame;
    end
  end

  logic [6*PORCH_W+2*SIZE_W+DIV_W+1:0] w_all;
  assign w_all = {sw_o, bp_o, fp_o, act_o, div_o, dir_o, frame_en_o};

  // R6
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(w_all));

  // R7
  protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && protect_o) |=> $stable(w_all));
endmodule

// File: rtl/ptg_pixdiv.sv
module ptg_pixdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = !dir || (cnt >= div_m1);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ptg_axis.sv
module ptg_axis
  import ptg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 11,
  localparam int CW = (SIZE_W > PORCH_W) ? SIZE_W : PORCH_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [PORCH_W-1:0] sw,
  input  logic [PORCH_W-1:0] bp,
  input  logic [PORCH_W-1:0] fp,
  input  logic [SIZE_W-1:0]  act,
  output ptg_phase_e         phase_o,
  output logic               last_o
);
  logic [CW-1:0] cnt, limit;
  logic          wrap;

  always_comb begin
    unique case (phase_o)
      PH_SYNC:  limit = CW'(sw);
      PH_BACK:  limit = CW'(bp);
      PH_ACT:   limit = CW'(act);
      default:  limit = CW'(fp);
    endcase
  end

  assign wrap   = (cnt >= limit);
  assign last_o = (phase_o == PH_FRONT) && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      phase_o <= PH_SYNC;
    end else if (adv) begin
      if (wrap) begin
        cnt     <= '0;
        phase_o <= ptg_phase_e'(phase_o + 2'd1);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(cnt) && $stable(phase_o)));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import ptg_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 11,
  parameter int DIV_W   = 8,
  parameter int DEF_ACT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              o_pclk_en,
  output logic              o_hsync,
  output logic              o_vsync,
  output logic              o_de,
  output logic              o_frame_irq
);
  logic [1:0][PORCH_W-1:0] sw, bp, fp;
  logic [1:0][SIZE_W-1:0]  act;
  logic [DIV_W-1:0]        div_m1;
  logic dir, frame_en, video_en, protect, gie, fie, stat_clr;
  logic pclk_tick, frame_tick, run, irq_set;
  logic [1:0]  adv, last;
  ptg_phase_e  ph [2];

  ptg_regs #(
    .PORCH_W(PORCH_W), .SIZE_W(SIZE_W), .DIV_W(DIV_W), .DEF_ACT(DEF_ACT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_tick(frame_tick),
    .sw_o(sw), .bp_o(bp), .fp_o(fp), .act_o(act), .div_o(div_m1), .dir_o(dir),
    .frame_en_o(frame_en), .video_en_o(video_en), .protect_o(protect),
    .gie_o(gie), .fie_o(fie), .stat_clr_o(stat_clr)
  );

  ptg_pixdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .dir(dir), .div_m1(div_m1), .tick_o(pclk_tick)
  );

  assign adv[0] = pclk_tick;
  assign adv[1] = pclk_tick && last[0];

  // index 0 is the horizontal axis, index 1 the vertical axis
  for (genvar a = 0; a < 2; a++) begin : g_axis
    ptg_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W)) u_axis (
      .clk(clk), .rst(rst), .adv(adv[a]),
      .sw(sw[a]), .bp(bp[a]), .fp(fp[a]), .act(act[a]),
      .phase_o(ph[a]), .last_o(last[a])
    );
  end

  assign frame_tick = pclk_tick && last[0] && last[1];
  assign run        = video_en && frame_en;
  assign irq_set    = frame_tick && gie && fie && video_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_pclk_en <= 1'b0;
      o_hsync   <= 1'b0;
      o_vsync   <= 1'b0;
      o_de      <= 1'b0;
    end else begin
      o_pclk_en <= run && pclk_tick;
      o_hsync   <= run && (ph[0] == PH_SYNC);
      o_vsync   <= run && (ph[1] == PH_SYNC);
      o_de      <= run && (ph[0] == PH_ACT) && (ph[1] == PH_ACT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           o_frame_irq <= 1'b0;
    else if (irq_set)  o_frame_irq <= 1'b1;
    else if (stat_clr) o_frame_irq <= 1'b0;
  end

  // R4
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (rst)
    o_de |-> (!o_hsync && !o_vsync));

  // R5
  div_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pclk_tick && !frame_tick && dir && (div_m1 != '0)) |=> !pclk_tick);

  // R8
  video_off_chk: assert property (@(posedge clk) disable iff (rst)
    !video_en |=> (!o_hsync && !o_vsync && !o_de && !o_pclk_en));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (o_frame_irq && !stat_clr) |=> o_frame_irq);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !irq_set) |=> !o_frame_irq);
endmodule

// File: tb/panel_timing_gen_bench.sv
`timescale 1ns/1ps
module panel_timing_gen_bench;
  typedef struct { int sw; int bp; int act; int fp; } ax_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic o_pclk_en, o_hsync, o_vsync, o_de, o_frame_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int m_fr, m_vs, m_de, m_hshi, m_hsr, m_pc, m_fde;

  always #2.5 clk = ~clk;

  panel_timing_gen u_panel_timing_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .o_pclk_en(o_pclk_en), .o_hsync(o_hsync), .o_vsync(o_vsync),
    .o_de(o_de), .o_frame_irq(o_frame_irq)
  );

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(int video, int frame, int dir, int div);
    return 32'(video) | (32'(frame) << 1) | (32'(dir) << 2) | (32'(div) << 8);
  endfunction

  task automatic set_timing(input ax_t h, input ax_t v);
    wr(3'd2, 32'(h.sw) | (32'(h.bp) << 8) | (32'(h.fp) << 16));
    wr(3'd1, 32'(v.sw) | (32'(v.bp) << 8) | (32'(v.fp) << 16));
    wr(3'd3, 32'(h.act) | (32'(v.act) << 16));
  endtask

  task automatic wait_rise();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (o_vsync && guard < 20000);
    do begin @(negedge clk); guard++; end while (!o_vsync && guard < 20000);
  endtask

  // measures one frame from an o_vsync rise up to the next rise
  task automatic measure(input bit synced);
    bit prev_hs = 0;
    bit seen_low = 0;
    if (!synced) wait_rise();
    m_fr = 0; m_vs = 0; m_de = 0; m_hshi = 0; m_hsr = 0; m_pc = 0; m_fde = -1;
    forever begin
      m_fr++;
      if (o_vsync) m_vs++;
      if (o_de) begin
        if (m_fde < 0) m_fde = m_fr - 1;
        m_de++;
      end
      if (o_hsync) begin
        m_hshi++;
        if (!prev_hs) m_hsr++;
      end
      prev_hs = o_hsync;
      if (o_pclk_en) m_pc++;
      @(negedge clk);
      if (!o_vsync) seen_low = 1;
      else if (seen_low) break;
      if (m_fr > 20000) break;
    end
  endtask

  task automatic check_frame(input string tag, input ax_t h, input ax_t v, input int d);
    int ht = h.sw + h.bp + h.act + h.fp + 4;
    int vt = v.sw + v.bp + v.act + v.fp + 4;
    chk({tag, " R2 hsync pulses per frame"}, m_hsr, vt);
    chk({tag, " R2 hsync high cycles"}, m_hshi, (h.sw + 1) * d * vt);
    chk({tag, " R3 frame cycles"}, m_fr, ht * vt * d);
    chk({tag, " R3 vsync high cycles"}, m_vs, (v.sw + 1) * ht * d);
    chk({tag, " R4 de cycles"}, m_de, (h.act + 1) * (v.act + 1) * d);
    chk({tag, " R4 first de offset"}, m_fde, ((v.sw + v.bp + 2) * ht + h.sw + h.bp + 2) * d);
    chk({tag, " R5 pclk pulses"}, m_pc, ht * vt);
  endtask

  task automatic quiet_window(input string tag, input int n);
    int hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (o_hsync || o_vsync || o_de || o_pclk_en) hits++;
    end
    chk(tag, hits, 0);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ax_t ha, va, hb, vb, hc, vc;
    ha = '{sw: 1, bp: 2, act: 7, fp: 1};
    va = '{sw: 0, bp: 1, act: 4, fp: 1};
    hb = '{sw: 0, bp: 1, act: 5, fp: 2};
    vb = '{sw: 1, bp: 0, act: 3, fp: 0};
    hc = '{sw: 2, bp: 0, act: 3, fp: 0};
    vc = '{sw: 0, bp: 0, act: 2, fp: 2};

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 hsync", int'(o_hsync), 0);
    chk("R1 vsync", int'(o_vsync), 0);
    chk("R1 de", int'(o_de), 0);
    chk("R1 pclk_en", int'(o_pclk_en), 0);
    chk("R1 irq", int'(o_frame_irq), 0);
    quiet_window("R1 idle after reset", 120);

    // config A, direction clear: divisor field has no effect (R5)
    set_timing(ha, va);
    wr(3'd0, ctrl_word(1, 1, 0, 3));
    measure(0);
    check_frame("cfgA dir0", ha, va, 1);

    // divider sweep (R5)
    for (int k = 0; k < 3; k++) begin
      wr(3'd0, ctrl_word(1, 1, 1, k));
      measure(0);
      check_frame($sformatf("cfgA div%0d", k + 1), ha, va, k + 1);
    end

    // R6: writes mid-frame do not disturb the running frame
    wr(3'd0, ctrl_word(1, 1, 0, 0));
    measure(0);
    fork
      measure(0);
      begin
        wait_rise();
        repeat (20) @(negedge clk);
        set_timing(hb, vb);
        wr(3'd0, ctrl_word(1, 1, 1, 2));
      end
    join
    chk("R6 running frame keeps old length", m_fr, 15 * 10);
    measure(1);
    check_frame("R6 next frame new", hb, vb, 3);

    // R7: protect holds off the load
    wr(3'd6, 32'd1);
    set_timing(hc, vc);
    wr(3'd0, ctrl_word(1, 1, 1, 1));
    measure(0);
    chk("R7 protected frame 1", m_fr, 12 * 8 * 3);
    measure(1);
    chk("R7 protected frame 2", m_fr, 12 * 8 * 3);
    fork
      measure(1);
      begin
        repeat (10) @(negedge clk);
        wr(3'd6, 32'd0);
      end
    join
    chk("R7 unprotect frame still old", m_fr, 12 * 8 * 3);
    measure(1);
    check_frame("R7 pending applied", hc, vc, 2);

    // R9 / R10 interrupt
    chk("R9 no irq while disabled", int'(o_frame_irq), 0);
    wr(3'd4, 32'd3);
    wait_rise();
    chk("R9 irq set at frame start", int'(o_frame_irq), 1);
    wr(3'd5, 32'd0);
    chk("R10 write zero keeps irq", int'(o_frame_irq), 1);
    wr(3'd5, 32'd1);
    chk("R10 write one clears irq", int'(o_frame_irq), 0);
    wait_rise();
    chk("R9 irq set again", int'(o_frame_irq), 1);
    wr(3'd4, 32'd1);
    wr(3'd5, 32'd1);
    wait_rise();
    wait_rise();
    chk("R9 frame enable clear blocks irq", int'(o_frame_irq), 0);
    wr(3'd4, 32'd2);
    wait_rise();
    chk("R9 global enable clear blocks irq", int'(o_frame_irq), 0);

    // R8 enables
    wr(3'd0, ctrl_word(1, 0, 1, 1));
    repeat (300) @(negedge clk);
    quiet_window("R8 frame enable clear idles output", 300);
    wr(3'd0, ctrl_word(1, 1, 1, 1));
    measure(0);
    check_frame("R8 restart", hc, vc, 2);
    wr(3'd0, ctrl_word(0, 1, 1, 1));
    @(negedge clk);
    quiet_window("R8 video enable clear idles output", 300);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule